// File: doc/BRIEF.md
# Vector Fixed-Point Multiply Unit

This unit executes multiply-class instructions against a private bank of 128 registers, each 32 bits wide. An instruction word names two source registers (A and B), a destination register and an element count. Once accepted, the unit walks through consecutive register indices, handling one element per clock. For each element it forms a signed product, rounds it if asked, shifts it right, and stores the result. The product is either 16 by 16 bits or 32 by 16 bits, and the right shift is 0, 8 or 16 bits.

Three modes exist. In element-wise multiply, each product goes to its own destination register. In scaled accumulate, A is multiplied by register 1, which acts as the scale, and B is added. In dot product, all the products are summed into a single destination register. Register 0 always reads as zero. A host port, usable while the unit is idle, loads operands and reads back results.

Top module: `vmul_unit`

## Requirements
- R1: Instruction fields are: bits 31:28 size code, bits 27:24 count, bit 23 round, bits 22:21 mode, bits 20:14 source A, bits 13:7 destination, bits 6:0 source B. An instruction runs count+1 elements. Element i reads A+i and B+i and writes D+i. With size code 0 and mode 0 (multiply), the result is the signed product of the low 16 bits of each operand.
- R2: Size codes 1 and 2 are 16×16 products arithmetically shifted right by 8 and 16 bits. Codes 4, 5 and 6 take all 32 bits of A times the signed low 16 bits of B, shifted right by 0, 8 and 16 bits. The low 32 bits of the shifted value are stored.
- R3: When bit 23 is set, 2^(shift-1) is added to the product before the shift. With a shift of 0, the round bit changes nothing.
- R4: Mode 2 stores (A × signed low 16 bits of register 1), after round and shift, plus the full 32 bits of B, modulo 2^32.
- R5: Mode 1 adds up the shifted products of all elements, modulo 2^32, and writes only register D. Registers D+1 onward are left unchanged.
- R6: Register 0 reads as zero. Writes to it, from the engine or from the host port, are discarded.
- R7: Busy rises on the clock edge that accepts an instruction and stays high for exactly count+1 cycles. instr_ready is the inverse of busy.
- R8: An instruction presented while busy is not accepted. A host write presented while busy is discarded.
- R9: Size codes 3 and 7 through 15, and mode 3, are reserved. Such an instruction is accepted and keeps the unit busy for count+1 cycles, but changes no register.
- R10: After reset, busy is 0, instr_ready is 1 and every register reads 0.
- R11: Register indices wrap modulo 128 as the element index advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction word is offered |
| instr_ready | output | 1 | The unit can accept an instruction |
| instr_word | input | 32 | Instruction word |
| busy | output | 1 | An instruction is executing |
| host_we | input | 1 | Host write strobe (honoured only while idle) |
| host_addr | input | 7 | Host register index, used for both read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read of the register at host_addr |

## Verification
Two situations are hard to reach from the ports. The first is a run whose destination range wraps past index 127 through register 0 and into the scale register. The second is an instruction offered during a run while the host also tries to write. To reach the first, the bench issues a run that starts at destination 126. To reach the second, it holds instr_valid high with a different word, and pulses host_we, on the first busy cycle. A reference model in the bench executes every instruction sequentially. After each instruction the bench compares the whole register bank against that model, so overlaps between the source and destination ranges are covered too.

// File: rtl/vmul_pkg.sv
// Shared constants and types for the vector multiply unit.
// Assumes a fixed 32-bit instruction layout whose field positions are decoded below.
package vmul_pkg;
    localparam int DATA_W    = 32;
    localparam int REG_COUNT = 128;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int CNT_W     = 4;
    localparam int SHAMT_W   = 5;

    typedef enum logic [1:0] {
        MODE_MUL   = 2'd0,
        MODE_DOT   = 2'd1,
        MODE_SCALE = 2'd2,
        MODE_RSVD  = 2'd3
    } vmul_mode_e;

    typedef struct packed {
        logic               legal;
        logic               wide;
        logic [SHAMT_W-1:0] shamt;
        logic               rnd;
        vmul_mode_e         mode;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   sa;
        logic [IDX_W-1:0]   dst;
        logic [IDX_W-1:0]   sb;
    } vmul_op_t;
endpackage

// File: rtl/vmul_decode.sv
// Instruction decoder: splits a 32-bit word into an operation record.
// Assumes the layout size[31:28] cnt[27:24] rnd[23] mode[22:21] sa[20:14] d[13:7] sb[6:0].
module vmul_decode
    import vmul_pkg::*;
(
    input  logic [31:0] word,
    output vmul_op_t    op
);
    logic [3:0] size_code;
    logic       size_ok;

    // Field extraction and legality of the size/mode codes.
    always_comb begin
        size_code = word[31:28];
        unique case (size_code)
            4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6: size_ok = 1'b1;
            default:                            size_ok = 1'b0;
        endcase
        op.wide  = size_code[2];
        op.shamt = {size_code[1:0], 3'b000};
        op.cnt   = word[27:24];
        op.rnd   = word[23];
        op.mode  = vmul_mode_e'(word[22:21]);
        op.sa    = word[20:14];
        op.dst   = word[13:7];
        op.sb    = word[6:0];
        op.legal = size_ok && (op.mode != MODE_RSVD);
    end
endmodule

// File: rtl/vmul_regfile.sv
// Register bank: three combinational engine reads, one host read, one write port.
// Assumes index 0 is hard zero; writes aimed at it are dropped here.
module vmul_regfile #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_a_idx,
    input  logic [AW-1:0]    rd_b_idx,
    input  logic [AW-1:0]    rd_h_idx,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    output logic [WIDTH-1:0] rd_h,
    output logic [WIDTH-1:0] scale,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise write any index except zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read ports with index zero forced to zero.
    always_comb begin
        rd_a  = (rd_a_idx == '0) ? '0 : mem[rd_a_idx];
        rd_b  = (rd_b_idx == '0) ? '0 : mem[rd_b_idx];
        rd_h  = (rd_h_idx == '0) ? '0 : mem[rd_h_idx];
        scale = mem[1];
    end

    AST_R0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == '0); // R6
endmodule

// File: rtl/vmul_datapath.sv
// Per-element arithmetic: signed product, optional round, arithmetic shift, optional add of B.
// Assumes 16-bit second operand and at most 32-bit first operand; purely combinational.
module vmul_datapath
    import vmul_pkg::*;
(
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [DATA_W-1:0]  scale,
    input  logic               wide,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               rnd,
    input  vmul_mode_e         mode,
    output logic [DATA_W-1:0]  term
);
    localparam int PW = 2 * DATA_W;

    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] y_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] bias;
    logic signed [PW-1:0] shifted;
    logic [15:0]          y_src;

    // Operand extension, rounding bias and shift.
    always_comb begin
        x_ext   = wide ? {{(PW-DATA_W){a[DATA_W-1]}}, a} : {{(PW-16){a[15]}}, a[15:0]};
        y_src   = (mode == MODE_SCALE) ? scale[15:0] : b[15:0];
        y_ext   = {{(PW-16){y_src[15]}}, y_src};
        prod    = x_ext * y_ext;
        bias    = (rnd && (shamt != '0)) ? (PW'(1) << (shamt - 1'b1)) : '0;
        shifted = (prod + bias) >>> shamt;
        term    = shifted[DATA_W-1:0] + ((mode == MODE_SCALE) ? b : '0);
    end

    logic unused_hi;
    assign unused_hi = &{1'b0, shifted[PW-1:DATA_W]};
endmodule

// File: rtl/vmul_unit.sv
// Top: accepts one instruction when idle, sequences its elements, and arbitrates the write port.
// Assumes the host only reads and writes registers while busy is low.
module vmul_unit
    import vmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [31:0]       instr_word,
    output logic              busy,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    vmul_op_t          dec_op;
    vmul_op_t          op_q;
    logic [CNT_W-1:0]  elem_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] a_val, b_val, scale_val, term;
    logic [IDX_W-1:0]  a_idx, b_idx, eng_idx, wr_idx;
    logic [DATA_W-1:0] eng_data, wr_data;
    logic              last, is_dot, eng_we, wr_en;

    vmul_decode u_dec (
        .word (instr_word),
        .op   (dec_op)
    );

    // Element index offsets applied to the latched base indices (wrap modulo bank size).
    always_comb begin
        a_idx = op_q.sa + IDX_W'(elem_q);
        b_idx = op_q.sb + IDX_W'(elem_q);
        last  = (elem_q == op_q.cnt);
        is_dot = (op_q.mode == MODE_DOT);
    end

    vmul_regfile #(.WIDTH(DATA_W), .DEPTH(REG_COUNT)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (a_idx),
        .rd_b_idx (b_idx),
        .rd_h_idx (host_addr),
        .rd_a     (a_val),
        .rd_b     (b_val),
        .rd_h     (host_rdata),
        .scale    (scale_val),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    vmul_datapath u_dp (
        .a     (a_val),
        .b     (b_val),
        .scale (scale_val),
        .wide  (op_q.wide),
        .shamt (op_q.shamt),
        .rnd   (op_q.rnd),
        .mode  (op_q.mode),
        .term  (term)
    );

    // Engine write request and the shared write port (engine owns it while busy).
    always_comb begin
        eng_we   = busy && op_q.legal && (!is_dot || last);
        eng_idx  = is_dot ? op_q.dst : (op_q.dst + IDX_W'(elem_q));
        eng_data = is_dot ? (acc_q + term) : term;
        wr_en    = busy ? eng_we : host_we;
        wr_idx   = busy ? eng_idx : host_addr;
        wr_data  = busy ? eng_data : host_wdata;
    end

    // Sequencer: latch on accept, step one element per cycle, drop busy after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            elem_q <= '0;
            acc_q  <= '0;
            op_q   <= '0;
        end else if (!busy) begin
            if (instr_valid) begin
                busy   <= 1'b1;
                elem_q <= '0;
                acc_q  <= '0;
                op_q   <= dec_op;
            end
        end else begin
            acc_q <= acc_q + term;
            if (last) busy   <= 1'b0;
            else      elem_q <= elem_q + 1'b1;
        end
    end

    assign instr_ready = !busy;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_valid)); // R7
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(elem_q) == $past(op_q.cnt))); // R7
    AST_ELEM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (elem_q <= op_q.cnt)); // R7
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> $stable(op_q)); // R8
    AST_DOT_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_dot && !last) |-> !wr_en); // R5
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_q.legal) |-> !wr_en); // R9
endmodule

// File: tb/sim_vmul_unit.sv
// Directed bench with a sequential reference model of the register bank.
module sim_vmul_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic        instr_ready;
    logic [31:0] instr_word;
    logic        busy;
    logic        host_we;
    logic [6:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] shadow [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    vmul_unit u0 (
        .clk (clk), .rst_n (rst_n),
        .instr_valid (instr_valid), .instr_ready (instr_ready), .instr_word (instr_word),
        .busy (busy), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_rdata (host_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] sz, input logic [3:0] cnt,
                                       input logic rnd, input logic [1:0] mode,
                                       input logic [6:0] sa, input logic [6:0] d,
                                       input logic [6:0] sb);
        return {sz, cnt, rnd, mode, sa, d, sb};
    endfunction

    function automatic logic [31:0] ref_term(input logic [3:0] sz, input logic rnd,
                                             input logic [1:0] mode, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] s);
        longint x, y, p;
        int sh;
        logic [31:0] r;
        sh = 8 * int'(sz[1:0]);
        x = sz[2] ? longint'($signed(a)) : longint'($signed(a[15:0]));
        y = (mode == 2'd2) ? longint'($signed(s[15:0])) : longint'($signed(b[15:0]));
        p = x * y;
        if (rnd && sh > 0) p = p + (longint'(1) <<< (sh - 1));
        p = p >>> sh;
        r = p[31:0];
        if (mode == 2'd2) r = r + b;
        return r;
    endfunction

    function automatic logic [31:0] rd_sh(input logic [6:0] i);
        return (i == 7'd0) ? 32'd0 : shadow[i];
    endfunction

    // Reference execution of one instruction, element by element.
    task automatic model_apply(input logic [31:0] w);
        logic [3:0] sz; logic [3:0] cnt; logic rnd; logic [1:0] mode;
        logic [6:0] sa, d, sb, ia, ib, id;
        logic [31:0] acc, t;
        logic legal;
        {sz, cnt, rnd, mode, sa, d, sb} = w;
        legal = (sz inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6}) && (mode != 2'd3);
        if (!legal) return;
        acc = 0;
        for (int i = 0; i <= int'(cnt); i++) begin
            ia = sa + 7'(i); ib = sb + 7'(i); id = d + 7'(i);
            t = ref_term(sz, rnd, mode, rd_sh(ia), rd_sh(ib), rd_sh(7'd1));
            if (mode == 2'd1) acc = acc + t;
            else if (id != 0) shadow[id] = t;
        end
        if (mode == 2'd1 && d != 0) shadow[d] = acc;
    endtask

    task automatic host_write(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        if (a != 0) shadow[a] = v;
    endtask

    task automatic compare_all(input string tag);
        for (int r = 0; r < 128; r++) begin
            host_addr = 7'(r);
            #1;
            check($sformatf("%s reg %0d", tag, r), host_rdata, rd_sh(7'(r)));
        end
    endtask

    // Issue one instruction; optionally disturb the first busy cycle; verify run length.
    task automatic issue(input string tag, input logic [31:0] w, input bit disturb);
        int bcnt;
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        if (disturb) begin
            instr_word = mk(4'd0, 4'd0, 1'b0, 2'd0, 7'd2, 7'd100, 7'd3);
            host_we = 1'b1; host_addr = 7'd100; host_wdata = 32'hBAD0_BAD0;
            @(negedge clk);
            bcnt = 1;
        end else begin
            bcnt = 0;
        end
        instr_valid = 1'b0; host_we = 1'b0;
        while (busy && bcnt < 40) begin
            check({tag, " R7 ready"}, 32'(instr_ready), 32'(!busy));
            bcnt++;
            @(negedge clk);
        end
        check({tag, " R7 busy cycles"}, 32'(bcnt), 32'(int'(w[27:24]) + 1));
        model_apply(w);
        compare_all(tag);
    endtask

    task automatic t_reset;
        check("R10 busy after reset", 32'(busy), 32'd0);
        check("R10 ready after reset", 32'(instr_ready), 32'd1);
        compare_all("R10 reset");
    endtask

    task automatic t_load;
        logic [31:0] seed;
        seed = 32'h1234_5678;
        for (int r = 2; r < 64; r++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            host_write(7'(r), seed);
        end
        host_write(7'd1, 32'h0000_FF80);
    endtask

    task automatic t_mul16;
        issue("R1 mul16", mk(4'd0, 4'd3, 1'b0, 2'd0, 7'd10, 7'd70, 7'd20), 1'b0);
        issue("R1 mul16 overlap", mk(4'd0, 4'd4, 1'b0, 2'd0, 7'd30, 7'd31, 7'd5), 1'b0);
    endtask

    task automatic t_shift;
        issue("R2 sr8", mk(4'd1, 4'd2, 1'b0, 2'd0, 7'd11, 7'd80, 7'd21), 1'b0);
        issue("R2 sr16", mk(4'd2, 4'd2, 1'b0, 2'd0, 7'd12, 7'd84, 7'd22), 1'b0);
        issue("R2 wide", mk(4'd4, 4'd1, 1'b0, 2'd0, 7'd13, 7'd88, 7'd23), 1'b0);
        issue("R2 wide sr8", mk(4'd5, 4'd1, 1'b0, 2'd0, 7'd14, 7'd90, 7'd24), 1'b0);
        issue("R2 wide sr16", mk(4'd6, 4'd1, 1'b0, 2'd0, 7'd15, 7'd92, 7'd25), 1'b0);
    endtask

    task automatic t_round;
        host_write(7'd40, 32'h0000_0180);
        host_write(7'd41, 32'h0000_0001);
        issue("R3 round sr8 half", mk(4'd1, 4'd0, 1'b1, 2'd0, 7'd40, 7'd95, 7'd41), 1'b0);
        issue("R3 round sr8", mk(4'd1, 4'd3, 1'b1, 2'd0, 7'd16, 7'd96, 7'd26), 1'b0);
        issue("R3 round sr0", mk(4'd0, 4'd2, 1'b1, 2'd0, 7'd17, 7'd100, 7'd27), 1'b0);
        issue("R3 round wide sr16", mk(4'd6, 4'd2, 1'b1, 2'd0, 7'd18, 7'd104, 7'd28), 1'b0);
    endtask

    task automatic t_scale;
        issue("R4 scale", mk(4'd1, 4'd3, 1'b0, 2'd2, 7'd33, 7'd108, 7'd43), 1'b0);
        host_write(7'd1, 32'h0000_0300);
        issue("R4 scale wide round", mk(4'd5, 4'd2, 1'b1, 2'd2, 7'd34, 7'd112, 7'd44), 1'b0);
    endtask

    task automatic t_dot;
        issue("R5 dot", mk(4'd0, 4'd5, 1'b0, 2'd1, 7'd50, 7'd115, 7'd55), 1'b0);
        issue("R5 dot sr8", mk(4'd1, 4'd15, 1'b1, 2'd1, 7'd2, 7'd118, 7'd40), 1'b0);
    endtask

    task automatic t_r0_wrap;
        host_write(7'd0, 32'hDEAD_BEEF);
        host_addr = 7'd0; #1;
        check("R6 host write to reg0", host_rdata, 32'd0);
        issue("R6 R11 wrap through reg0", mk(4'd0, 4'd3, 1'b0, 2'd0, 7'd126, 7'd126, 7'd60), 1'b0);
        issue("R6 src reg0", mk(4'd0, 4'd1, 1'b0, 2'd2, 7'd0, 7'd66, 7'd61), 1'b0);
    endtask

    task automatic t_busy_ignore;
        issue("R8 disturb", mk(4'd0, 4'd3, 1'b0, 2'd0, 7'd3, 7'd120, 7'd9), 1'b1);
    endtask

    task automatic t_reserved;
        issue("R9 size3", mk(4'd3, 4'd2, 1'b0, 2'd0, 7'd5, 7'd6, 7'd7), 1'b0);
        issue("R9 size9", mk(4'd9, 4'd0, 1'b0, 2'd0, 7'd5, 7'd6, 7'd7), 1'b0);
        issue("R9 mode3", mk(4'd0, 4'd4, 1'b0, 2'd3, 7'd5, 7'd6, 7'd7), 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 128; r++) shadow[r] = 32'd0;
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
        host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_mul16();
        t_shift();
        t_round();
        t_scale();
        t_dot();
        t_r0_wrap();
        t_busy_ignore();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule